// File: doc/BRIEF.md
# Aliased Multi-Width FP/Vector Register File

This block is a register file of 32 entries that software sees as three register sets of different widths: a 64-bit scalar floating-point set, a 128-bit short-vector set and a 256-bit long-vector set. All three sets share one physical array. Register n of the scalar set is the low 64 bits of register n of the short-vector set. That register is in turn the low 128 bits of register n of the long-vector set.

There are two combinational read ports and one write port. The write port is registered on the rising clock edge. Every port has a 2-bit view select. A read returns the bits of the selected width in the low part of a 256-bit bus, with zeros above. A write narrower than 256 bits either keeps or clears the bits above its width, as the `PRESERVE_UPPER` parameter selects. A read that addresses the entry being written in the same cycle sees the value the entry will hold after the edge.

Top module: `fpv_regfile`

## Requirements
- R1: A synchronous active-high reset clears every bit of all 32 entries, so every read of every view returns zero after reset.
- R2: A write with view 2'b10 (256-bit) stores all 256 data bits, and a 256-bit read of that index returns them unchanged.
- R3: A read with view 2'b00 returns bits [63:0] of the entry, and a read with view 2'b01 returns bits [127:0]. In both cases the read bus is zero above the returned width.
- R4: All views of index n address the same storage. Data written through the 64-bit view appears in bits [63:0] of the 128-bit and 256-bit reads of index n.
- R5: With PRESERVE_UPPER=1, a 64-bit or 128-bit write leaves the entry's bits above the written width unchanged.
- R6: With PRESERVE_UPPER=0, a 64-bit or 128-bit write sets the entry's bits above the written width, up to bit 255, to zero.
- R7: A write with view 2'b11 asserts wr_err in the same cycle and changes no entry. A legal write leaves wr_err low.
- R8: A read with view 2'b11 asserts that port's error flag and returns all zeros.
- R9: A read of the index being written by a legal write in the same cycle returns the post-write entry, merged according to the write policy and masked to the read view.
- R10: A write changes only the entry at its own index.
- R11: The two read ports are independent and may read different indices and views in the same cycle.
- R12: While wr_en is low, no entry changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_view | input | 2 | Write width: 00=64, 01=128, 10=256, 11 illegal |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 256 | Write data, low bits used for narrow views |
| wr_err | output | 1 | Illegal write view flag |
| rd0_view | input | 2 | Read port 0 width select |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_data | output | 256 | Read port 0 data, zero above view width |
| rd0_err | output | 1 | Read port 0 illegal view flag |
| rd1_view | input | 2 | Read port 1 width select |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_data | output | 256 | Read port 1 data, zero above view width |
| rd1_err | output | 1 | Read port 1 illegal view flag |

## Verification
The bench builds two copies of the file side by side, one with PRESERVE_UPPER=1 and one with PRESERVE_UPPER=0, and drives them with identical stimulus. Every narrow write therefore exercises both upper-bit policies in the same cycle, and this covers the merge rules of R5 and R6 and the merged bypass of R9. Writing a full-width pattern first leaves non-zero upper bits, so the difference between keeping and clearing them shows at the read ports.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

    localparam int S_W = 64;
    localparam int M_W = 128;
    localparam int L_W = 256;

    typedef enum logic [1:0] {
        VIEW_S   = 2'b00,
        VIEW_M   = 2'b01,
        VIEW_L   = 2'b10,
        VIEW_BAD = 2'b11
    } view_e;

    typedef logic [L_W-1:0] entry_t;

    typedef struct packed {
        logic   en;
        logic   [4:0] idx;
        entry_t entry;
    } wr_cmd_t;

    function automatic entry_t view_mask(view_e v);
        entry_t m;
        m = '0;
        case (v)
            VIEW_S:  m[S_W-1:0] = '1;
            VIEW_M:  m[M_W-1:0] = '1;
            VIEW_L:  m          = '1;
            default: m          = '0;
        endcase
        return m;
    endfunction

    function automatic logic view_ok(view_e v);
        return v != VIEW_BAD;
    endfunction

endpackage

// File: rtl/vrf_merge.sv
module vrf_merge
    import vrf_pkg::*;
#(
    parameter bit PRESERVE_UPPER = 1'b1
) (
    input  entry_t     old_entry,
    input  entry_t     wdata,
    input  logic [1:0] view,
    output entry_t     new_entry,
    output logic       legal
);
    view_e  v;
    entry_t m;

    always_comb begin
        v     = view_e'(view);
        m     = view_mask(v);
        legal = view_ok(v);
    end

    generate
        if (PRESERVE_UPPER) begin : g_keep
            always_comb new_entry = (old_entry & ~m) | (wdata & m);
        end else begin : g_clear
            always_comb new_entry = wdata & m;
        end
    endgenerate
endmodule

// File: rtl/vrf_store.sv
module vrf_store
    import vrf_pkg::*;
#(
    parameter int NREG  = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  entry_t                    wentry,
    output logic [NREG-1:0][L_W-1:0]  mem_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (we) begin
            mem_q[widx] <= wentry;
        end
    end
endmodule

// File: rtl/vrf_rport.sv
module vrf_rport
    import vrf_pkg::*;
#(
    parameter int NREG  = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][L_W-1:0]  mem_q,
    input  logic [IDX_W-1:0]          ridx,
    input  logic [1:0]                rview,
    input  logic                      byp_en,
    input  logic [IDX_W-1:0]          byp_idx,
    input  entry_t                    byp_entry,
    output entry_t                    rdata,
    output logic                      rerr
);
    entry_t sel;
    view_e  v;

    always_comb begin
        v   = view_e'(rview);
        sel = mem_q[ridx];
        if (byp_en && (byp_idx == ridx)) begin
            sel = byp_entry;
        end
        rerr  = !view_ok(v);
        rdata = rerr ? '0 : (sel & view_mask(v));
    end
endmodule

// File: rtl/fpv_regfile.sv
module fpv_regfile
    import vrf_pkg::*;
#(
    parameter int NREG           = 32,
    parameter bit PRESERVE_UPPER = 1'b1,
    localparam int IDX_W         = $clog2(NREG),
    localparam int NRD           = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_view,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [L_W-1:0]   wr_data,
    output logic             wr_err,
    input  logic [1:0]       rd0_view,
    input  logic [IDX_W-1:0] rd0_idx,
    output logic [L_W-1:0]   rd0_data,
    output logic             rd0_err,
    input  logic [1:0]       rd1_view,
    input  logic [IDX_W-1:0] rd1_idx,
    output logic [L_W-1:0]   rd1_data,
    output logic             rd1_err
);
    logic [NREG-1:0][L_W-1:0] mem_q;
    entry_t                   merged;
    logic                     legal;
    wr_cmd_t                  cmd;

    logic [NRD-1:0][IDX_W-1:0] ridx_a;
    logic [NRD-1:0][1:0]       rview_a;
    entry_t                    rdata_a [NRD];
    logic [NRD-1:0]            rerr_a;

    vrf_merge #(.PRESERVE_UPPER(PRESERVE_UPPER)) u_merge (
        .old_entry (mem_q[wr_idx]),
        .wdata     (wr_data),
        .view      (wr_view),
        .new_entry (merged),
        .legal     (legal)
    );

    always_comb begin
        cmd.en    = wr_en && legal;
        cmd.idx   = 5'(wr_idx);
        cmd.entry = merged;
        wr_err    = wr_en && !legal;
    end

    vrf_store #(.NREG(NREG)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (cmd.en),
        .widx   (wr_idx),
        .wentry (cmd.entry),
        .mem_q  (mem_q)
    );

    assign ridx_a[0]  = rd0_idx;
    assign ridx_a[1]  = rd1_idx;
    assign rview_a[0] = rd0_view;
    assign rview_a[1] = rd1_view;

    generate
        for (genvar gi = 0; gi < NRD; gi++) begin : g_rd
            vrf_rport #(.NREG(NREG)) u_rport (
                .mem_q     (mem_q),
                .ridx      (ridx_a[gi]),
                .rview     (rview_a[gi]),
                .byp_en    (cmd.en),
                .byp_idx   (wr_idx),
                .byp_entry (cmd.entry),
                .rdata     (rdata_a[gi]),
                .rerr      (rerr_a[gi])
            );
        end
    endgenerate

    assign rd0_data = rdata_a[0];
    assign rd1_data = rdata_a[1];
    assign rd0_err  = rerr_a[0];
    assign rd1_err  = rerr_a[1];
endmodule

// File: rtl/fpv_regfile_chk.sv
module fpv_regfile_chk
    import vrf_pkg::*;
#(
    parameter int NREG           = 32,
    parameter bit PRESERVE_UPPER = 1'b1,
    localparam int IDX_W         = $clog2(NREG)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [1:0]               wr_view,
    input logic [IDX_W-1:0]         wr_idx,
    input logic [NREG-1:0][L_W-1:0] mem_q,
    input logic [1:0]               rd0_view,
    input logic [L_W-1:0]           rd0_data,
    input logic                     rd0_err
);
    // R1: reset empties the whole array by the following edge
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (mem_q == '0));

    // R7: illegal write view leaves the array untouched
    a_r7_bad_view_no_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_view == 2'b11) |=> (mem_q == $past(mem_q)));

    // R12: no request, no change
    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (mem_q == $past(mem_q)));

    // R8: illegal read view gives zeros on the bus
    a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
        rd0_err |-> (rd0_data == '0 && rd0_view == 2'b11));

    generate
        if (PRESERVE_UPPER) begin : g_keep
            // R5: scalar write keeps bits above 64
            a_r5_upper_kept: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_view == 2'b00) |=>
                (mem_q[$past(wr_idx)][L_W-1:S_W] == $past(mem_q[wr_idx][L_W-1:S_W])));
        end else begin : g_clear
            // R6: scalar write clears bits above 64
            a_r6_upper_cleared: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_view == 2'b00) |=>
                (mem_q[$past(wr_idx)][L_W-1:S_W] == '0));
        end
    endgenerate
endmodule

bind fpv_regfile fpv_regfile_chk #(.NREG(NREG), .PRESERVE_UPPER(PRESERVE_UPPER)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_view  (wr_view),
    .wr_idx   (wr_idx),
    .mem_q    (mem_q),
    .rd0_view (rd0_view),
    .rd0_data (rd0_data),
    .rd0_err  (rd0_err)
);

// File: tb/fpv_regfile_test.sv
`timescale 1ns/1ps
module fpv_regfile_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_view = 2'b00;
    logic [4:0]   wr_idx = '0;
    logic [255:0] wr_data = '0;
    logic [1:0]   rd_view [2];
    logic [4:0]   rd_idx  [2];

    logic [255:0] pd0, pd1, zd0, zd1;
    logic         pe0, pe1, ze0, ze1, pwe, zwe;

    logic [255:0] exp_p [32];
    logic [255:0] exp_z [32];

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fpv_regfile #(.PRESERVE_UPPER(1'b1)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_err(pwe),
        .rd0_view(rd_view[0]), .rd0_idx(rd_idx[0]), .rd0_data(pd0), .rd0_err(pe0),
        .rd1_view(rd_view[1]), .rd1_idx(rd_idx[1]), .rd1_data(pd1), .rd1_err(pe1)
    );

    fpv_regfile #(.PRESERVE_UPPER(1'b0)) uut_z (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_err(zwe),
        .rd0_view(rd_view[0]), .rd0_idx(rd_idx[0]), .rd0_data(zd0), .rd0_err(ze0),
        .rd1_view(rd_view[1]), .rd1_idx(rd_idx[1]), .rd1_data(zd1), .rd1_err(ze1)
    );

    function automatic logic [255:0] vmask(logic [1:0] v);
        case (v)
            2'b00:   return {192'b0, {64{1'b1}}};
            2'b01:   return {128'b0, {128{1'b1}}};
            2'b10:   return {256{1'b1}};
            default: return '0;
        endcase
    endfunction

    function automatic logic [255:0] pat(int s);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = 32'h9E3779B9 * 32'(s * 8 + k + 1);
        return r;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [1:0] v, int i, logic [255:0] d);
        logic [255:0] m;
        if (v == 2'b11) return;
        m = vmask(v);
        exp_p[i] = (exp_p[i] & ~m) | (d & m);
        exp_z[i] = d & m;
    endtask

    task automatic wr(logic [1:0] v, int i, logic [255:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_view = v; wr_idx = 5'(i); wr_data = d;
        @(posedge clk);
        model_write(v, i, d);
        #1 wr_en = 1'b0;
    endtask

    // read one port of both copies and compare with the model
    task automatic rd_chk(string req, int port, logic [1:0] v, int i);
        logic [255:0] ep, ez;
        rd_view[port] = v; rd_idx[port] = 5'(i);
        #1;
        ep = exp_p[i] & vmask(v);
        ez = exp_z[i] & vmask(v);
        check($sformatf("%s keep p%0d", req, port), port == 0 ? pd0 : pd1, ep);
        check($sformatf("%s clear p%0d", req, port), port == 0 ? zd0 : zd1, ez);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 32; i++) begin
            rd_chk("R1", 0, 2'b10, i);
            rd_chk("R1", 1, 2'b00, i);
        end
    endtask

    task automatic t_full();
        wr(2'b10, 3, pat(1));
        rd_chk("R2", 0, 2'b10, 3);
        check("R2 raw", pd0, pat(1));
    endtask

    task automatic t_views();
        rd_chk("R3 s", 0, 2'b00, 3);
        check("R3 s raw", pd0, {192'b0, pat(1)[63:0]});
        rd_chk("R3 m", 1, 2'b01, 3);
        check("R3 m raw", pd1, {128'b0, pat(1)[127:0]});
    endtask

    task automatic t_alias_policy();
        wr(2'b10, 7, pat(2));
        wr(2'b00, 7, pat(3));
        rd_chk("R4", 0, 2'b10, 7);
        check("R4 low", pd0[63:0], pat(3)[63:0]);
        check("R5 upper kept", pd0[255:64], pat(2)[255:64]);
        check("R6 upper cleared", zd0[255:64], '0);
        wr(2'b10, 8, pat(4));
        wr(2'b01, 8, pat(5));
        rd_chk("R5/R6 m", 1, 2'b10, 8);
        check("R5 m upper kept", pd1[255:128], pat(4)[255:128]);
        check("R6 m upper cleared", zd1[255:128], '0);
        rd_chk("R4 m view", 0, 2'b01, 8);
    endtask

    task automatic t_bad_write();
        @(negedge clk);
        wr_en = 1'b1; wr_view = 2'b11; wr_idx = 5'd3; wr_data = pat(9);
        #1;
        check("R7 err keep", {255'b0, pwe}, 256'd1);
        check("R7 err clear", {255'b0, zwe}, 256'd1);
        @(posedge clk);
        #1 wr_en = 1'b0;
        rd_chk("R7 unchanged", 0, 2'b10, 3);
        @(negedge clk);
        wr_en = 1'b1; wr_view = 2'b00; wr_idx = 5'd20; wr_data = pat(10);
        #1;
        check("R7 legal no err", {255'b0, pwe}, '0);
        @(posedge clk);
        model_write(2'b00, 20, pat(10));
        #1 wr_en = 1'b0;
    endtask

    task automatic t_bad_read();
        rd_view[0] = 2'b11; rd_idx[0] = 5'd3;
        #1;
        check("R8 data", pd0, '0);
        check("R8 err", {255'b0, pe0}, 256'd1);
        rd_view[0] = 2'b10;
        #1;
        check("R8 err low on legal", {255'b0, pe0}, '0);
    endtask

    task automatic t_bypass();
        logic [255:0] m;
        wr(2'b10, 5, pat(6));
        @(negedge clk);
        wr_en = 1'b1; wr_view = 2'b01; wr_idx = 5'd5; wr_data = pat(7);
        rd_view[0] = 2'b10; rd_idx[0] = 5'd5;
        rd_view[1] = 2'b00; rd_idx[1] = 5'd5;
        #1;
        m = vmask(2'b01);
        check("R9 keep L", pd0, (pat(6) & ~m) | (pat(7) & m));
        check("R9 clear L", zd0, pat(7) & m);
        check("R9 keep S", pd1, pat(7) & vmask(2'b00));
        @(posedge clk);
        model_write(2'b01, 5, pat(7));
        #1 wr_en = 1'b0;
        rd_chk("R9 after", 0, 2'b10, 5);
    endtask

    task automatic t_isolation();
        wr(2'b10, 0, pat(11));
        wr(2'b10, 31, pat(12));
        rd_chk("R10 n1", 0, 2'b10, 1);
        rd_chk("R10 n30", 0, 2'b10, 30);
        rd_chk("R10 n6", 1, 2'b10, 6);
        rd_chk("R10 n7", 1, 2'b10, 7);
    endtask

    task automatic t_ports();
        rd_view[0] = 2'b10; rd_idx[0] = 5'd0;
        rd_view[1] = 2'b01; rd_idx[1] = 5'd31;
        #1;
        check("R11 port0", pd0, pat(11));
        check("R11 port1", pd1, {128'b0, pat(12)[127:0]});
    endtask

    task automatic t_idle();
        @(negedge clk);
        wr_en = 1'b0; wr_view = 2'b10; wr_idx = 5'd0; wr_data = pat(13);
        @(posedge clk);
        #1;
        rd_chk("R12", 0, 2'b10, 0);
        check("R12 raw", pd0, pat(11));
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin exp_p[i] = '0; exp_z[i] = '0; end
        rd_view[0] = 2'b10; rd_idx[0] = '0;
        rd_view[1] = 2'b10; rd_idx[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_full();
        t_views();
        t_alias_policy();
        t_bad_write();
        t_bad_read();
        t_bypass();
        t_isolation();
        t_ports();
        t_idle();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule